// File: doc/BRIEF.md
# Stereo Zero-Cross Gain Commit Unit

This block sits between a control-register write port and a stereo pair of programmable-gain stages. Software first stores a new gain code and a mute flag for each channel. These are only pending values. The active gain does not change until a write arrives with its commit bit set. A commit bit in a write to either channel moves the pending settings of both channels, so a stereo change is applied to both sides at once.

Each channel has its own zero-cross enable. When a channel has it enabled, the commit waits until the sign of that channel's audio changes, so a gain step does not land in the middle of a waveform. A free-running timeout tick bounds the wait. A commit that has not found a crossing is forced on the second tick after the request. The outputs are the active gain code and mute flag of each channel, ready to drive the gain stages.

The gain code width is a parameter. The default is six bits: code 0 is the lowest gain and each step adds 0.75 dB, so code 23 is unity. The same unit at seven bits serves an output volume stage.

Top module: `vol_sync_updater`

## Requirements
- R1: A write without the commit bit changes only the pending setting of the addressed channel; the active gain and mute outputs of both channels keep their values.
- R2: A write with its commit bit set schedules both channels to take their pending settings, whichever channel the write addressed; this includes the value carried by that same write.
- R3: For a channel with zero-cross disabled, the outputs still show the old setting in the cycle after the write is captured, and show the new setting from the following cycle onward.
- R4: For a channel with zero-cross enabled, a pending setting is applied on a valid sample whose sign bit differs from the sign bit of the previous valid sample of that channel. Samples whose valid strobe is low are ignored.
- R5: A valid sample equal to exactly zero counts as a crossing.
- R6: With zero-cross enabled and no crossing, the pending setting is applied at the second timeout tick counted after the commit request. A tick in the cycle of the request itself is not counted.
- R7: A new write while a commit is pending replaces the pending value but does not restart the timeout. The value applied is the latest one written.
- R8: Reset sets both active gains to RESET_GAIN (23, unity gain at the default width), clears both mute flags, disables zero-cross on both channels, clears any pending commit, and treats the previous sample of each channel as non-negative.
- R9: Write layout: wr_sel 0 addresses left and 1 addresses right. wr_data bit GAIN_W+2 is the commit bit, bit GAIN_W+1 is the zero-cross enable, bit GAIN_W is the mute flag, and bits GAIN_W-1:0 are the gain code. The zero-cross enable takes effect as soon as the write is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Channel addressed by the write (0 left, 1 right) |
| wr_data | input | GAIN_W+3 | Commit bit, zero-cross enable, mute flag, gain code |
| smp_l_valid | input | 1 | Left sample valid |
| smp_l | input | SMP_W | Left signed sample |
| smp_r_valid | input | 1 | Right sample valid |
| smp_r | input | SMP_W | Right signed sample |
| tmo_tick | input | 1 | Free-running timeout tick, one cycle wide |
| gain_l | output | GAIN_W | Active left gain code |
| gain_r | output | GAIN_W | Active right gain code |
| mute_l | output | 1 | Active left mute flag |
| mute_r | output | 1 | Active right mute flag |

## Verification
The bench uses the default parameters: a six-bit gain code, 16-bit samples and a reset code of 23. With these values it can drive both ends of the code range (0 and 63), write negative, positive and exactly-zero samples, and check the exact reset value at the outputs. The ticks and samples are driven by hand, one at a time. This lets the bench reach the corner cases directly: a commit that must wait for a crossing, a commit forced on the second tick, and a value replaced mid-wait without a restart. It can also show a reset that clears a pending commit.

// File: rtl/vu_pkg.sv
package vu_pkg;

    localparam int NUM_CH = 2;
    localparam int CH_L   = 0;
    localparam int CH_R   = 1;

    // Control bits carried above the gain code in a write
    typedef struct packed {
        logic commit;
        logic zc_en;
        logic mute;
    } wr_flags_t;

    // Timeout progress of a pending commit
    typedef enum logic {
        TMO_FIRST  = 1'b0,
        TMO_SECOND = 1'b1
    } tmo_phase_t;

    function automatic wr_flags_t unpack_flags(input logic [2:0] hi);
        wr_flags_t f;
        f.commit = hi[2];
        f.zc_en  = hi[1];
        f.mute   = hi[0];
        return f;
    endfunction

    // Sign change against the previous sample, or an exact zero
    function automatic logic sign_flip(input logic prev_neg,
                                       input logic cur_neg,
                                       input logic cur_zero);
        return (prev_neg != cur_neg) || cur_zero;
    endfunction

endpackage

// File: rtl/vu_write_decode.sv
module vu_write_decode
    import vu_pkg::*;
#(
    parameter int          GAIN_W     = 6,
    parameter int unsigned RESET_GAIN = 23
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic                             wr_sel,
    input  logic [GAIN_W+2:0]                wr_data,
    output logic [NUM_CH-1:0][GAIN_W-1:0]    pend_gain,
    output logic [NUM_CH-1:0]                pend_mute,
    output logic [NUM_CH-1:0]                zc_en,
    output logic                             upd_req
);
    localparam int FLAG_LO = GAIN_W;

    wr_flags_t flags;

    assign flags   = unpack_flags(wr_data[FLAG_LO+2:FLAG_LO]);
    assign upd_req = wr_en && flags.commit;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_sel == 1'(ch));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_gain[ch] <= GAIN_W'(RESET_GAIN);
                pend_mute[ch] <= 1'b0;
                zc_en[ch]     <= 1'b0;
            end else if (hit) begin
                pend_gain[ch] <= wr_data[GAIN_W-1:0];
                pend_mute[ch] <= flags.mute;
                zc_en[ch]     <= flags.zc_en;
            end
        end
    end

endmodule

// File: rtl/vu_zc_detect.sv
module vu_zc_detect
    import vu_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp,
    output logic             xing
);
    logic prev_neg_q;
    logic cur_neg;
    logic cur_zero;

    assign cur_neg  = smp[SMP_W-1];
    assign cur_zero = (smp == '0);
    assign xing     = smp_valid && sign_flip(prev_neg_q, cur_neg, cur_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_neg_q <= 1'b0;
        end else if (smp_valid) begin
            prev_neg_q <= cur_neg;
        end
    end

endmodule

// File: rtl/vu_commit.sv
module vu_commit
    import vu_pkg::*;
#(
    parameter int          GAIN_W     = 6,
    parameter int unsigned RESET_GAIN = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_req,
    input  logic              zc_en,
    input  logic              xing,
    input  logic              tick,
    input  logic [GAIN_W-1:0] pend_gain,
    input  logic              pend_mute,
    output logic [GAIN_W-1:0] act_gain,
    output logic              act_mute,
    output logic              pend_q
);
    tmo_phase_t phase_q;
    logic       tmo_fire;
    logic       commit;

    assign tmo_fire = tick && (phase_q == TMO_SECOND);
    assign commit   = pend_q && (!zc_en || xing || tmo_fire);

    // Pending flag and timeout phase
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            phase_q <= TMO_FIRST;
        end else if (commit) begin
            pend_q  <= upd_req;
            phase_q <= TMO_FIRST;
        end else if (upd_req && !pend_q) begin
            pend_q  <= 1'b1;
            phase_q <= TMO_FIRST;
        end else if (pend_q && tick) begin
            phase_q <= TMO_SECOND;
        end
    end

    // Active setting
    always_ff @(posedge clk) begin
        if (rst) begin
            act_gain <= GAIN_W'(RESET_GAIN);
            act_mute <= 1'b0;
        end else if (commit) begin
            act_gain <= pend_gain;
            act_mute <= pend_mute;
        end
    end

endmodule

// File: rtl/vol_sync_updater.sv
module vol_sync_updater
    import vu_pkg::*;
#(
    parameter int          GAIN_W     = 6,
    parameter int          SMP_W      = 16,
    parameter int unsigned RESET_GAIN = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [GAIN_W+2:0] wr_data,
    input  logic              smp_l_valid,
    input  logic [SMP_W-1:0]  smp_l,
    input  logic              smp_r_valid,
    input  logic [SMP_W-1:0]  smp_r,
    input  logic              tmo_tick,
    output logic [GAIN_W-1:0] gain_l,
    output logic [GAIN_W-1:0] gain_r,
    output logic              mute_l,
    output logic              mute_r
);
    logic [NUM_CH-1:0][GAIN_W-1:0] pend_gain;
    logic [NUM_CH-1:0]             pend_mute;
    logic [NUM_CH-1:0]             zc_en;
    logic                          upd_req;
    logic [NUM_CH-1:0]             smp_valid_v;
    logic [NUM_CH-1:0][SMP_W-1:0]  smp_v;
    logic [NUM_CH-1:0]             xing;
    logic [NUM_CH-1:0][GAIN_W-1:0] act_gain;
    logic [NUM_CH-1:0]             act_mute;
    logic [NUM_CH-1:0]             pend_q;

    assign smp_valid_v[CH_L] = smp_l_valid;
    assign smp_valid_v[CH_R] = smp_r_valid;
    assign smp_v[CH_L]       = smp_l;
    assign smp_v[CH_R]       = smp_r;

    vu_write_decode #(
        .GAIN_W     (GAIN_W),
        .RESET_GAIN (RESET_GAIN)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pend_gain (pend_gain),
        .pend_mute (pend_mute),
        .zc_en     (zc_en),
        .upd_req   (upd_req)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        vu_zc_detect #(
            .SMP_W (SMP_W)
        ) u_zc (
            .clk       (clk),
            .rst       (rst),
            .smp_valid (smp_valid_v[ch]),
            .smp       (smp_v[ch]),
            .xing      (xing[ch])
        );

        vu_commit #(
            .GAIN_W     (GAIN_W),
            .RESET_GAIN (RESET_GAIN)
        ) u_cm (
            .clk       (clk),
            .rst       (rst),
            .upd_req   (upd_req),
            .zc_en     (zc_en[ch]),
            .xing      (xing[ch]),
            .tick      (tmo_tick),
            .pend_gain (pend_gain[ch]),
            .pend_mute (pend_mute[ch]),
            .act_gain  (act_gain[ch]),
            .act_mute  (act_mute[ch]),
            .pend_q    (pend_q[ch])
        );
    end

    assign gain_l = act_gain[CH_L];
    assign gain_r = act_gain[CH_R];
    assign mute_l = act_mute[CH_L];
    assign mute_r = act_mute[CH_R];

endmodule

// File: rtl/vu_checker.sv
module vu_checker
    import vu_pkg::*;
#(
    parameter int          GAIN_W     = 6,
    parameter int unsigned RESET_GAIN = 23
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          upd_req,
    input logic                          tick,
    input logic [NUM_CH-1:0]             pend,
    input logic [NUM_CH-1:0]             zc_en,
    input logic [NUM_CH-1:0]             xing,
    input logic [NUM_CH-1:0][GAIN_W-1:0] gain,
    input logic [NUM_CH-1:0]             mute
);
    // R2: one commit bit arms both channels
    p_both_armed_r2: assert property (@(posedge clk) disable iff (rst)
        upd_req |=> (pend[CH_L] && pend[CH_R]));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // R1: nothing pending, nothing moves
        p_hold_r1: assert property (@(posedge clk) disable iff (rst)
            !pend[ch] |=> ($stable(gain[ch]) && $stable(mute[ch])));

        // R3: direct mode completes on the next edge
        p_direct_r3: assert property (@(posedge clk) disable iff (rst)
            (pend[ch] && !zc_en[ch] && !upd_req) |=> !pend[ch]);

        // R4: a crossing completes a waiting commit
        p_cross_r4: assert property (@(posedge clk) disable iff (rst)
            (pend[ch] && zc_en[ch] && xing[ch] && !upd_req) |=> !pend[ch]);

        // R6: without a crossing or a tick the commit keeps waiting
        p_wait_r6: assert property (@(posedge clk) disable iff (rst)
            (pend[ch] && zc_en[ch] && !xing[ch] && !tick) |=> pend[ch]);

        // R8: state right after reset
        p_reset_r8: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (gain[ch] == GAIN_W'(RESET_GAIN) && !mute[ch] && !pend[ch]));
    end

endmodule

bind vol_sync_updater vu_checker #(
    .GAIN_W     (GAIN_W),
    .RESET_GAIN (RESET_GAIN)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .upd_req (upd_req),
    .tick    (tmo_tick),
    .pend    (pend_q),
    .zc_en   (zc_en),
    .xing    (xing),
    .gain    (act_gain),
    .mute    (act_mute)
);

// File: tb/tb_vol_sync_updater.sv
module tb_vol_sync_updater;

    localparam int GAIN_W = 6;
    localparam int SMP_W  = 16;
    localparam int RST_G  = 23;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [GAIN_W+2:0] wr_data = '0;
    logic              smp_l_valid = 1'b0;
    logic [SMP_W-1:0]  smp_l = '0;
    logic              smp_r_valid = 1'b0;
    logic [SMP_W-1:0]  smp_r = '0;
    logic              tmo_tick = 1'b0;
    logic [GAIN_W-1:0] gain_l, gain_r;
    logic              mute_l, mute_r;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vol_sync_updater #(
        .GAIN_W     (GAIN_W),
        .SMP_W      (SMP_W),
        .RESET_GAIN (RST_G)
    ) dut (
        .clk (clk), .rst (rst),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .smp_l_valid (smp_l_valid), .smp_l (smp_l),
        .smp_r_valid (smp_r_valid), .smp_r (smp_r),
        .tmo_tick (tmo_tick),
        .gain_l (gain_l), .gain_r (gain_r),
        .mute_l (mute_l), .mute_r (mute_r)
    );

    // Vector: channel, write word, expected {mute,gain} for left and right
    typedef struct packed {
        logic              sel;
        logic [GAIN_W+2:0] data;
        logic [GAIN_W:0]   exp_l;
        logic [GAIN_W:0]   exp_r;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, {3'b000, 6'd40}, {1'b0, 6'd23}, {1'b0, 6'd23}},
        '{1'b1, {3'b001, 6'd10}, {1'b0, 6'd23}, {1'b0, 6'd23}},
        '{1'b0, {3'b100, 6'd40}, {1'b0, 6'd40}, {1'b1, 6'd10}},
        '{1'b1, {3'b100, 6'd63}, {1'b0, 6'd40}, {1'b0, 6'd63}},
        '{1'b0, {3'b101, 6'd0},  {1'b1, 6'd0},  {1'b0, 6'd63}},
        '{1'b0, {3'b000, 6'd5},  {1'b1, 6'd0},  {1'b0, 6'd63}},
        '{1'b1, {3'b000, 6'd1},  {1'b1, 6'd0},  {1'b0, 6'd63}},
        '{1'b0, {3'b100, 6'd2},  {1'b0, 6'd2},  {1'b0, 6'd1}}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lv();
        return {25'd0, mute_l, gain_l};
    endfunction

    function automatic int rv();
        return {25'd0, mute_r, gain_r};
    endfunction

    // Called at a falling edge; returns at the falling edge after capture
    task automatic wr(input logic sel, input logic [2:0] flg, input int g);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = {flg, GAIN_W'(g)};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic tick1();
        tmo_tick = 1'b1;
        @(negedge clk);
        tmo_tick = 1'b0;
    endtask

    task automatic sample(input logic sel, input logic vld, input int v);
        if (sel) begin
            smp_r_valid = vld; smp_r = SMP_W'(v);
        end else begin
            smp_l_valid = vld; smp_l = SMP_W'(v);
        end
        @(negedge clk);
        smp_l_valid = 1'b0;
        smp_r_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int prev_l;
        int prev_r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        check("R8 reset left", lv(), RST_G);
        check("R8 reset right", rv(), RST_G);

        // Table walk, zero-cross off: R1 R2 R3 R9
        prev_l = RST_G;
        prev_r = RST_G;
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i].sel, VEC[i].data[GAIN_W+2:GAIN_W], int'(VEC[i].data[GAIN_W-1:0]));
            check("R3 old value one cycle after write, left", lv(), prev_l);
            check("R3 old value one cycle after write, right", rv(), prev_r);
            @(negedge clk);
            check("R1/R2 table left", lv(), int'(VEC[i].exp_l));
            check("R1/R2 table right", rv(), int'(VEC[i].exp_r));
            prev_l = int'(VEC[i].exp_l);
            prev_r = int'(VEC[i].exp_r);
        end

        // R4: commit waits for a sign change
        wr(1'b0, 3'b010, 30);
        wr(1'b1, 3'b010, 31);
        check("R1 zc values staged only", lv(), 2);
        wr(1'b1, 3'b110, 31);
        @(negedge clk);
        check("R4 waiting left", lv(), 2);
        check("R4 waiting right", rv(), 1);
        sample(1'b0, 1'b0, -100);
        check("R4 invalid sample ignored", lv(), 2);
        sample(1'b0, 1'b1, 100);
        check("R4 same sign no commit", lv(), 2);
        sample(1'b0, 1'b1, -5);
        check("R4 crossing commits left", lv(), 30);
        check("R4 right still waiting", rv(), 1);
        // R5: exact zero counts
        sample(1'b1, 1'b1, 0);
        check("R5 zero sample commits right", rv(), 31);

        // R6: timeout on the second tick
        wr(1'b0, 3'b110, 12);
        @(negedge clk);
        check("R6 no tick yet", lv(), 30);
        tick1();
        check("R6 after first tick", lv(), 30);
        tick1();
        check("R6 after second tick", lv(), 12);

        // R7: rewrite keeps the running timeout
        wr(1'b0, 3'b110, 20);
        tick1();
        check("R7 after first tick", lv(), 12);
        wr(1'b0, 3'b010, 21);
        check("R7 rewrite not applied early", lv(), 12);
        tick1();
        check("R7 replaced value on second tick", lv(), 21);

        // R8: reset drops a pending commit and zero-cross enable
        wr(1'b0, 3'b111, 44);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset mid-wait left", lv(), RST_G);
        check("R8 reset mid-wait right", rv(), RST_G);
        sample(1'b0, 1'b1, -1);
        tick1();
        tick1();
        check("R8 nothing pending after reset", lv(), RST_G);
        wr(1'b0, 3'b100, 33);
        @(negedge clk);
        check("R8 zero-cross disabled after reset", lv(), 33);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule